// File: doc/BRIEF.md
# Strobe-Handshake FIFO with Ready Flags

This block is a first-in first-out buffer, 64 words deep and 5 bits wide by default. It is driven by two strobes instead of a valid/ready interface. A producer raises `shift_in` to write the word on `data_in` and lowers it to commit the write. A consumer raises `shift_out` to take the word shown on `data_out` and lowers it to move on to the next word. Two registered flags report status. `in_ready` means a write may start now, and `out_ready` means `data_out` holds a valid unread word.

The storage is a dual-port memory with separate write and read pointers, and it can be inferred as block RAM. Each pointer carries one extra wrap bit, so a full buffer and an empty buffer can be told apart. Both strobes pass through a two-flop synchronizer, and all edge detection happens in the single system clock domain. A master reset empties the buffer. When the output enable is low, the data outputs go to high impedance, so several buffers can share one bus.

A strobe edge that arrives when the matching flag is low is ignored and sets a sticky protocol-error flag. There is one exception. If `shift_in` rises while the buffer is full, the write waits. It is taken as soon as a word has been read out, provided `shift_in` is still high at that point.

Top module: `strobe_fifo`

## Requirements
- R1: While `rst` is high and just after it falls, `out_ready` is 0, `in_ready` is 1, `proto_err` is 0 and `data_out` is all zeros (with `out_en` = 1).
- R2: Words leave on `data_out` in the order they were written, with their values unchanged.
- R3: After an accepted rise of `shift_in`, `in_ready` is 0 for as long as `shift_in` stays high. It returns to 1 after `shift_in` falls, provided space remains.
- R4: After 64 committed writes with no read, `in_ready` stays 0 and no further word is stored, until a word is shifted out.
- R5: `out_ready` goes to 0 within 3 clock cycles of `shift_out` rising and stays 0 while `shift_out` is high. After `shift_out` falls, the next stored word is presented and `out_ready` returns to 1. If nothing is stored, `out_ready` stays 0.
- R6: When a write into an empty buffer is committed, `out_ready` rises with that word on `data_out` no more than 6 clock cycles after `shift_in` falls.
- R7: A rise of `shift_out` while `out_ready` is 0 does not remove a word and sets `proto_err` to 1. `proto_err` stays 1 through later valid traffic and is cleared only by `rst`.
- R8: A rise of `shift_in` while `in_ready` is 0 and the buffer is not full stores nothing and sets `proto_err`. An example is a low gap of one clock between two strobes.
- R9: If `shift_in` rises while the buffer is full and is held high, the word on `data_in` is stored once a word has been shifted out. This sets no error, and `in_ready` stays 0 because the buffer is full again.
- R10: While `out_en` is 0, every bit of `data_out` is high impedance. When `out_en` returns to 1, the held word reappears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high master reset |
| shift_in | input | 1 | Write strobe: rise stores `data_in`, fall commits it |
| data_in | input | 5 | Word to write, held stable while `shift_in` is high |
| shift_out | input | 1 | Read strobe: rise takes the word, fall advances to the next |
| out_en | input | 1 | Output enable; 0 puts `data_out` in high impedance |
| data_out | output | 5 | Oldest unread word (zero after reset) |
| in_ready | output | 1 | A write may start |
| out_ready | output | 1 | `data_out` holds a valid unread word |
| proto_err | output | 1 | Sticky flag for a strobe edge that arrived while its flag was low |

## Verification
A pointer that slips by one shows up at once as a wrong value or a swapped order in the scoreboard comparison, on the first read after the fault. A wrong full or empty decode appears within a few cycles of reaching the boundary. In that case `in_ready` either fails to stay low after the 64th word, or `out_ready` rises on an empty buffer or stays low on a filled one. A wrong choice between a deferred write and a protocol error shows in `proto_err` within three cycles of the offending edge, and as a missing or extra word when the buffer is drained.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;
  // Synchronized strobe: current level plus one-cycle edge pulses.
  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } strobe_t;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync
  import strobe_fifo_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    strobe_in,
  output strobe_t ev
);
  // STAGES synchronizer flops followed by one history flop for edge detection.
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], strobe_in};
  end

  assign ev.level = sh[STAGES-1];
  assign ev.rise  = sh[STAGES-1] & ~sh[STAGES];
  assign ev.fall  = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/fifo_ram.sv
module fifo_ram #(
  parameter int WIDTH = 5,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);
  localparam int WORDS = 1 << AW;
  logic [WIDTH-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl
  import strobe_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  strobe_t       si,
  input  strobe_t       so,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          load_out,
  output logic          in_ready,
  output logic          out_ready,
  output logic          proto_err
);
  logic [AW:0] wptr, rptr, fill;
  logic pend_wr, pend_rd, arm, avail1;
  logic full, empty, space, avail, rd_go;

  assign fill  = wptr - rptr;
  assign empty = (wptr == rptr);
  assign full  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
  // Space for a new write: not full, no write in progress, strobe idle.
  assign space = !full && !pend_wr && !si.level;
  // A word can be offered: present, no read in progress, strobe idle.
  assign avail = !empty && !pend_rd && !so.level;

  assign wr_en   = (si.rise && in_ready) || (arm && si.level && !full && !pend_wr);
  assign rd_go   = so.rise && out_ready;
  assign wr_addr = wptr[AW-1:0];
  assign rd_addr = rptr[AW-1:0];
  // Memory read data matches rptr once avail has held for one cycle.
  assign load_out = avail1;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      rptr      <= '0;
      pend_wr   <= 1'b0;
      pend_rd   <= 1'b0;
      arm       <= 1'b0;
      avail1    <= 1'b0;
      in_ready  <= 1'b1;
      out_ready <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      in_ready  <= space;
      avail1    <= avail;
      out_ready <= avail1 && avail;

      if (wr_en) begin
        pend_wr <= 1'b1;
        arm     <= 1'b0;
      end else if (si.rise && !in_ready) begin
        if (full && !pend_wr) arm <= 1'b1;
        else                  proto_err <= 1'b1;
      end
      if (si.fall) begin
        arm <= 1'b0;
        if (pend_wr) begin
          wptr    <= wptr + 1'b1;
          pend_wr <= 1'b0;
        end
      end

      if (rd_go)        pend_rd   <= 1'b1;
      else if (so.rise) proto_err <= 1'b1;
      if (so.fall && pend_rd) begin
        rptr    <= rptr + 1'b1;
        pend_rd <= 1'b0;
      end
    end
  end

  p_fill_bound_r4: assert property (@(posedge clk) disable iff (rst)
    fill <= (AW+1)'(DEPTH));
  p_full_blocks_ready_r4: assert property (@(posedge clk) disable iff (rst)
    full |-> !in_ready);
  p_oready_drop_r5: assert property (@(posedge clk) disable iff (rst)
    so.level |=> !out_ready);
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);
  p_wptr_step_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(wptr) |-> (wptr == (AW+1)'($past(wptr) + 1'b1)));
  p_no_read_empty_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(rptr) |-> $past(!empty));
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
  import strobe_fifo_pkg::*;
#(
  parameter int WIDTH       = 5,
  parameter int DEPTH       = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_in,
  input  logic [WIDTH-1:0] data_in,
  input  logic             shift_out,
  input  logic             out_en,
  output logic [WIDTH-1:0] data_out,
  output logic             in_ready,
  output logic             out_ready,
  output logic             proto_err
);
  localparam int AW = $clog2(DEPTH);

  strobe_t          si_ev, so_ev;
  logic             wr_en, load_out;
  logic [AW-1:0]    wr_addr, rd_addr;
  logic [WIDTH-1:0] ram_q, data_q;

  strobe_sync #(.STAGES(SYNC_STAGES)) u_si_sync (
    .clk(clk), .rst(rst), .strobe_in(shift_in), .ev(si_ev));
  strobe_sync #(.STAGES(SYNC_STAGES)) u_so_sync (
    .clk(clk), .rst(rst), .strobe_in(shift_out), .ev(so_ev));

  fifo_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .si(si_ev), .so(so_ev),
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .load_out(load_out), .in_ready(in_ready), .out_ready(out_ready),
    .proto_err(proto_err));

  fifo_ram #(.WIDTH(WIDTH), .AW(AW)) u_ram (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(data_in),
    .rd_addr(rd_addr), .rd_data(ram_q));

  always_ff @(posedge clk) begin
    if (rst)           data_q <= '0;
    else if (load_out) data_q <= ram_q;
  end

  assign data_out = out_en ? data_q : {WIDTH{1'bz}};

  p_ready_has_data_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(out_ready) |-> $past(load_out));
endmodule

// File: tb/tb_strobe_fifo.sv
module tb_strobe_fifo;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       shift_in = 1'b0, shift_out = 1'b0, out_en = 1'b1;
  logic [4:0] data_in = '0;
  logic [4:0] data_out;
  logic       in_ready, out_ready, proto_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [4:0] sb[$];

  strobe_fifo dut (
    .clk(clk), .rst(rst), .shift_in(shift_in), .data_in(data_in),
    .shift_out(shift_out), .out_en(out_en), .data_out(data_out),
    .in_ready(in_ready), .out_ready(out_ready), .proto_err(proto_err));

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    shift_in = 1'b0;
    shift_out = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    sb.delete();
    @(negedge clk);
  endtask

  task automatic wait_ir();
    int n = 0;
    while (!in_ready && n < 300) begin @(negedge clk); n++; end
    if (n >= 300) check(0, "R3 in_ready timeout", 0, 1);
  endtask

  task automatic wait_or();
    int n = 0;
    while (!out_ready && n < 300) begin @(negedge clk); n++; end
    if (n >= 300) check(0, "R5 out_ready timeout", 0, 1);
  endtask

  // Driver: one full write strobe; the expected word goes to the scoreboard.
  task automatic push(input logic [4:0] d);
    wait_ir();
    data_in = d;
    shift_in = 1'b1;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b0, "R3 in_ready low while shift_in high", in_ready, 0);
    @(negedge clk);
    shift_in = 1'b0;
    sb.push_back(d);
    repeat (4) @(negedge clk);
  endtask

  // Monitor: compare the offered word against the scoreboard, then read it.
  task automatic pop();
    logic [4:0] exp;
    wait_or();
    exp = (sb.size() > 0) ? sb.pop_front() : 5'h0;
    check(data_out === exp, "R2 word order and value", data_out, exp);
    shift_out = 1'b1;
    repeat (3) @(negedge clk);
    check(out_ready == 1'b0, "R5 out_ready low while shift_out high", out_ready, 0);
    @(negedge clk);
    shift_out = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat;
    // R1: reset state
    repeat (2) @(negedge clk);
    check(out_ready == 0, "R1 out_ready in reset", out_ready, 0);
    check(in_ready == 1, "R1 in_ready in reset", in_ready, 1);
    check(data_out === 5'h00, "R1 data_out in reset", data_out, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(proto_err == 0, "R1 proto_err after reset", proto_err, 0);
    check(out_ready == 0, "R1 out_ready after reset", out_ready, 0);

    // R6: latency from the commit into an empty buffer to out_ready
    data_in = 5'h15;
    shift_in = 1'b1;
    repeat (4) @(negedge clk);
    shift_in = 1'b0;
    sb.push_back(5'h15);
    lat = 0;
    while (!out_ready && lat < 20) begin @(negedge clk); lat++; end
    check(lat <= 6, "R6 out_ready latency", lat, 6);
    check(data_out === 5'h15, "R6 word on output", data_out, 5'h15);
    // R3: in_ready back high after the write
    check(in_ready == 1, "R3 in_ready returns high", in_ready, 1);

    // R10: output enable
    out_en = 1'b0;
    #1;
    check(data_out === 5'bzzzzz, "R10 high impedance when disabled", data_out, 0);
    out_en = 1'b1;
    #1;
    check(data_out === 5'h15, "R10 word back when enabled", data_out, 5'h15);
    pop();
    repeat (4) @(negedge clk);
    check(out_ready == 0, "R5 out_ready stays low when empty", out_ready, 0);

    // R2: concurrent streaming through the scoreboard
    fork
      for (int i = 0; i < 40; i++) push(5'((i * 7 + 3) & 31));
      for (int i = 0; i < 40; i++) pop();
    join
    check(sb.size() == 0, "R2 scoreboard drained", sb.size(), 0);
    check(proto_err == 0, "R2 no error on clean traffic", proto_err, 0);

    // R4: fill to 64 words
    do_reset();
    for (int i = 0; i < 64; i++) push(5'((i ^ 5) & 31));
    repeat (6) @(negedge clk);
    check(in_ready == 0, "R4 in_ready low when full", in_ready, 0);
    check(out_ready == 1, "R4 out_ready high when full", out_ready, 1);

    // R9: deferred write held on a full buffer
    data_in = 5'h1e;
    shift_in = 1'b1;
    repeat (10) @(negedge clk);
    check(in_ready == 0, "R9 in_ready low while held on full", in_ready, 0);
    check(proto_err == 0, "R9 no error for held write", proto_err, 0);
    pop();
    repeat (10) @(negedge clk);
    shift_in = 1'b0;
    sb.push_back(5'h1e);
    repeat (6) @(negedge clk);
    check(in_ready == 0, "R9 full again after deferred write", in_ready, 0);
    check(proto_err == 0, "R9 no error after deferred write", proto_err, 0);
    for (int i = 0; i < 64; i++) pop();
    repeat (6) @(negedge clk);
    check(out_ready == 0, "R4 empty after drain, no extra word", out_ready, 0);
    check(sb.size() == 0, "R9 all words drained", sb.size(), 0);

    // R7: read strobe on empty buffer
    do_reset();
    shift_out = 1'b1;
    repeat (4) @(negedge clk);
    shift_out = 1'b0;
    repeat (4) @(negedge clk);
    check(proto_err == 1, "R7 error on read while empty", proto_err, 1);
    check(out_ready == 0, "R7 out_ready still low", out_ready, 0);
    push(5'h0a);
    pop();
    check(proto_err == 1, "R7 error stays sticky", proto_err, 1);
    do_reset();
    check(proto_err == 0, "R7 cleared by reset", proto_err, 0);

    // R8: second write strobe after a one-clock low gap
    data_in = 5'h11;
    shift_in = 1'b1;
    repeat (4) @(negedge clk);
    shift_in = 1'b0;
    sb.push_back(5'h11);
    @(negedge clk);
    data_in = 5'h06;
    shift_in = 1'b1;
    repeat (4) @(negedge clk);
    shift_in = 1'b0;
    repeat (4) @(negedge clk);
    check(proto_err == 1, "R8 error on early shift_in", proto_err, 1);
    pop();
    repeat (10) @(negedge clk);
    check(out_ready == 0, "R8 ignored word not stored", out_ready, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule